// File: doc/BRIEF.md
# Two-Port RAM with Fixed Write Priority

This block is a synchronous two-port memory on one clock. Each port has its own address, write enable, write data and registered read data. Both ports may write in the same cycle. When they write the same word, a fixed port priority chosen by a parameter decides which value is kept. Because of this, the stored result never depends on the order in which processes run.

Each read is registered. The read data shows the word as it stood before the writes of that same edge. This holds even when the write comes from the other port. A synchronous active-low reset clears both read registers and leaves the array contents alone.

The ports are plain memory ports with no valid/ready handshake. An access is taken on every rising edge, so the block never applies back-pressure. A caller that does not want to write simply keeps its write enable low.

Top module: `dpram_prio`

## Requirements
- R1: A port with its write enable high stores its write data at its address on the rising clock edge.
- R2: Each port's read data, one edge after an address is presented, is the word held at that address before that edge's writes, including a write by the same port.
- R3: A read on one port at the address the other port writes in the same cycle returns the old word.
- R4: When both ports write different addresses in one cycle, both words are stored.
- R5: With PORT0_PRIORITY = 0 (default), a same-address write by both ports stores port 1's data.
- R6: With PORT0_PRIORITY = 1, a same-address write by both ports stores port 0's data.
- R7: A write by only one port is stored whatever the priority setting, even when the other port presents the same address.
- R8: While rst_n is low at a rising edge, both read data outputs become zero.
- R9: With its write enable low, a port's write data has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all accesses occur on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read registers |
| wr_en0 | input | 1 | Port 0 write enable |
| addr0 | input | ADDR_W | Port 0 word address |
| wdata0 | input | DATA_W | Port 0 write data |
| rdata0 | output | DATA_W | Port 0 registered read data |
| wr_en1 | input | 1 | Port 1 write enable |
| addr1 | input | ADDR_W | Port 1 word address |
| wdata1 | input | DATA_W | Port 1 write data |
| rdata1 | output | DATA_W | Port 1 registered read data |

## Verification
The bench builds two copies at the default 16-bit by 64-word size. One copy uses PORT0_PRIORITY = 0 and the other uses 1, and both are driven with identical stimulus. This lets each same-address collision be seen resolving both ways in the same cycle, while every non-colliding access must agree between the two copies. The 6-bit address keeps a full sweep of every word short, so each location is written and read back by both ports.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int unsigned NPORTS = 2;
  typedef enum logic { WIN_P1 = 1'b0, WIN_P0 = 1'b1 } win_e;
endpackage

// File: rtl/dpram_wr_arb.sv
module dpram_wr_arb
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W         = 6,
  parameter bit          PORT0_PRIORITY = 1'b0
) (
  input  logic [NPORTS-1:0]             req_we,
  input  logic [NPORTS-1:0][ADDR_W-1:0] req_addr,
  output logic [NPORTS-1:0]             grant_we
);
  localparam win_e WINNER = PORT0_PRIORITY ? WIN_P0 : WIN_P1;

  logic clash;
  assign clash = req_we[0] & req_we[1] & (req_addr[0] == req_addr[1]);

  generate
    if (WINNER == WIN_P0) begin : g_p0_wins
      assign grant_we[0] = req_we[0];
      assign grant_we[1] = req_we[1] & ~clash;
    end else begin : g_p1_wins
      assign grant_we[0] = req_we[0] & ~clash;
      assign grant_we[1] = req_we[1];
    end
  endgenerate
endmodule

// File: rtl/dpram_array.sv
module dpram_array
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORTS-1:0]             we,
  input  logic [NPORTS-1:0][ADDR_W-1:0] addr,
  input  logic [NPORTS-1:0][DATA_W-1:0] wdata,
  output logic [NPORTS-1:0][DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Grants never overlap on one address, so loop order cannot matter.
  always_ff @(posedge clk) begin
    for (int k = 0; k < int'(NPORTS); k++) begin
      if (we[k]) store[addr[k]] <= wdata[k];
    end
  end

  generate
    for (genvar p = 0; p < int'(NPORTS); p++) begin : g_rd
      always_ff @(posedge clk) begin
        if (!rst_n) rdata[p] <= '0;
        else        rdata[p] <= store[addr[p]];
      end
    end
  endgenerate
endmodule

// File: rtl/dpram_prio.sv
module dpram_prio
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned ADDR_W         = 6,
  parameter bit          PORT0_PRIORITY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en0,
  input  logic [ADDR_W-1:0] addr0,
  input  logic [DATA_W-1:0] wdata0,
  output logic [DATA_W-1:0] rdata0,
  input  logic              wr_en1,
  input  logic [ADDR_W-1:0] addr1,
  input  logic [DATA_W-1:0] wdata1,
  output logic [DATA_W-1:0] rdata1
);
  logic [NPORTS-1:0]             wr_req;
  logic [NPORTS-1:0]             wr_eff;
  logic [NPORTS-1:0][ADDR_W-1:0] addr_v;
  logic [NPORTS-1:0][DATA_W-1:0] wdata_v;
  logic [NPORTS-1:0][DATA_W-1:0] rdata_v;

  assign wr_req  = {wr_en1, wr_en0};
  assign addr_v  = {addr1, addr0};
  assign wdata_v = {wdata1, wdata0};
  assign rdata0  = rdata_v[0];
  assign rdata1  = rdata_v[1];

  dpram_wr_arb #(.ADDR_W(ADDR_W), .PORT0_PRIORITY(PORT0_PRIORITY)) u_arb (
    .req_we  (wr_req),
    .req_addr(addr_v),
    .grant_we(wr_eff)
  );

  dpram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_eff),
    .addr (addr_v),
    .wdata(wdata_v),
    .rdata(rdata_v)
  );
endmodule

// File: rtl/dpram_prio_chk.sv
module dpram_prio_chk #(
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned ADDR_W         = 6,
  parameter bit          PORT0_PRIORITY = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en0,
  input logic [ADDR_W-1:0] addr0,
  input logic [DATA_W-1:0] wdata0,
  input logic [DATA_W-1:0] rdata0,
  input logic              wr_en1,
  input logic [ADDR_W-1:0] addr1,
  input logic [DATA_W-1:0] wdata1,
  input logic [DATA_W-1:0] rdata1,
  input logic [1:0]        eff_we
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] shadow [DEPTH];
  logic [DEPTH-1:0]  known;
  logic [DATA_W-1:0] exp0_q, exp1_q;
  logic              kv0_q, kv1_q, in_rst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      known <= '0;
      kv0_q <= 1'b0;
      kv1_q <= 1'b0;
    end else begin
      exp0_q <= shadow[addr0];
      exp1_q <= shadow[addr1];
      kv0_q  <= known[addr0];
      kv1_q  <= known[addr1];
      if (PORT0_PRIORITY) begin
        if (wr_en1) begin shadow[addr1] <= wdata1; known[addr1] <= 1'b1; end
        if (wr_en0) begin shadow[addr0] <= wdata0; known[addr0] <= 1'b1; end
      end else begin
        if (wr_en0) begin shadow[addr0] <= wdata0; known[addr0] <= 1'b1; end
        if (wr_en1) begin shadow[addr1] <= wdata1; known[addr1] <= 1'b1; end
      end
    end
  end

  always_ff @(posedge clk) in_rst_q <= !rst_n;

  always_ff @(posedge clk) begin
    if (in_rst_q === 1'b1)
      AST_RST_CLEAR: assert (rdata0 == '0 && rdata1 == '0); // R8
  end

  AST_RD0_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    kv0_q |-> rdata0 == exp0_q); // R2

  AST_RD1_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    kv1_q |-> rdata1 == exp1_q); // R3

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_we[0] && eff_we[1]) |-> addr0 != addr1); // R4

  AST_BOTH_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en0 && wr_en1 && addr0 != addr1) |-> eff_we == 2'b11); // R4

  AST_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en0 && wr_en1 && addr0 == addr1) |->
      eff_we == (PORT0_PRIORITY ? 2'b01 : 2'b10)); // R5

  AST_LONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en0 != wr_en1) |-> eff_we == {wr_en1, wr_en0}); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en0 && !wr_en1) |-> eff_we == 2'b00); // R9
endmodule

bind dpram_prio dpram_prio_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PORT0_PRIORITY(PORT0_PRIORITY)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_en0(wr_en0), .addr0(addr0), .wdata0(wdata0), .rdata0(rdata0),
  .wr_en1(wr_en1), .addr1(addr1), .wdata1(wdata1), .rdata1(rdata1),
  .eff_we(wr_eff)
);

// File: tb/sim_dpram_prio.sv
module sim_dpram_prio;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we0 = 1'b0, we1 = 1'b0;
  logic [AW-1:0] a0 = '0, a1 = '0;
  logic [DW-1:0] d0 = '0, d1 = '0;
  logic [DW-1:0] q0_a, q1_a, q0_b, q1_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] ref_a [DEPTH];  // priority to port 1
  logic [DW-1:0] ref_b [DEPTH];  // priority to port 0
  bit            kn    [DEPTH];

  always #2 clk = ~clk;

  dpram_prio #(.DATA_W(DW), .ADDR_W(AW), .PORT0_PRIORITY(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en0(we0), .addr0(a0), .wdata0(d0), .rdata0(q0_a),
    .wr_en1(we1), .addr1(a1), .wdata1(d1), .rdata1(q1_a));

  dpram_prio #(.DATA_W(DW), .ADDR_W(AW), .PORT0_PRIORITY(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n),
    .wr_en0(we0), .addr0(a0), .wdata0(d0), .rdata0(q0_b),
    .wr_en1(we1), .addr1(a1), .wdata1(d1), .rdata1(q1_b));

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One access cycle on both copies; read data compared after the edge.
  task automatic cyc(string req, logic w0, logic [AW-1:0] x0, logic [DW-1:0] v0,
                     logic w1, logic [AW-1:0] x1, logic [DW-1:0] v1);
    logic [DW-1:0] e0a, e1a, e0b, e1b;
    bit k0, k1;
    @(negedge clk);
    we0 = w0; a0 = x0; d0 = v0; we1 = w1; a1 = x1; d1 = v1;
    e0a = ref_a[x0]; e1a = ref_a[x1]; e0b = ref_b[x0]; e1b = ref_b[x1];
    k0 = kn[x0]; k1 = kn[x1];
    if (w0) begin ref_b[x0] = v0; kn[x0] = 1'b1; end
    if (w1) begin ref_b[x1] = v1; ref_a[x1] = v1; kn[x1] = 1'b1; end
    if (w0 && !(w1 && x1 == x0)) ref_a[x0] = v0;
    if (w1 && !(w0 && x0 == x1)) ref_b[x1] = v1;
    if (w0 && w1 && x0 == x1) ref_b[x0] = v0;
    @(posedge clk);
    #1;
    if (k0) begin chk(req, "u0 rd0", q0_a, e0a); chk(req, "u1 rd0", q0_b, e0b); end
    if (k1) begin chk(req, "u0 rd1", q1_a, e1a); chk(req, "u1 rd1", q1_b, e1b); end
  endtask

  task automatic idle();
    @(negedge clk);
    we0 = 1'b0; we1 = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "u0 rd0", q0_a, '0); chk("R8", "u0 rd1", q1_a, '0);
    chk("R8", "u1 rd0", q0_b, '0); chk("R8", "u1 rd1", q1_b, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_fill();
    // R1 R4: port 0 fills low half, port 1 the high half, same cycles
    for (int i = 0; i < DEPTH / 2; i++)
      cyc("R4", 1'b1, AW'(i), DW'(i * 37 + 5), 1'b1, AW'(i + DEPTH / 2), DW'(i * 91 + 3));
    for (int i = 0; i < DEPTH; i++)
      cyc("R1", 1'b0, AW'(i), '0, 1'b0, AW'(DEPTH - 1 - i), '0);
  endtask

  task automatic t_collide();
    // R5 u0, R6 u1: both write address 9
    cyc("R5", 1'b1, AW'(9), 16'hAAAA, 1'b1, AW'(9), 16'h5555);
    cyc("R5", 1'b0, AW'(9), '0, 1'b0, AW'(9), '0);
    chk("R5", "u0 winner", q0_a, 16'h5555);
    chk("R6", "u1 winner", q0_b, 16'hAAAA);
    cyc("R6", 1'b1, AW'(40), 16'h1234, 1'b1, AW'(40), 16'h4321);
    cyc("R6", 1'b0, AW'(40), '0, 1'b0, AW'(40), '0);
    chk("R6", "u1 winner", q1_b, 16'h1234);
    chk("R5", "u0 winner", q1_a, 16'h4321);
  endtask

  task automatic t_cross();
    // R3: port 0 writes 12 while port 1 reads 12; R2: port 0 reads own write target
    cyc("R3", 1'b1, AW'(12), 16'hBEEF, 1'b0, AW'(12), 16'hFFFF);
    cyc("R2", 1'b0, AW'(12), '0, 1'b1, AW'(20), 16'hCAFE);
    chk("R2", "u0 new word", q0_a, 16'hBEEF);
    cyc("R3", 1'b0, AW'(20), '0, 1'b0, AW'(20), '0);
  endtask

  task automatic t_single();
    // R7: lone port 0 write at shared address, port 1 has priority in u0
    cyc("R7", 1'b1, AW'(33), 16'h0F0F, 1'b0, AW'(33), 16'hF0F0);
    cyc("R7", 1'b0, AW'(33), '0, 1'b0, AW'(33), '0);
    chk("R7", "u0 lone p0", q1_a, 16'h0F0F);
    cyc("R7", 1'b0, AW'(50), 16'h7777, 1'b1, AW'(50), 16'h3C3C);
    cyc("R7", 1'b0, AW'(50), '0, 1'b0, AW'(50), '0);
    chk("R7", "u1 lone p1", q0_b, 16'h3C3C);
  endtask

  task automatic t_ignore();
    // R9: data present with enables low leaves word 7 unchanged
    cyc("R9", 1'b0, AW'(7), 16'hDEAD, 1'b0, AW'(7), 16'hD00D);
    cyc("R9", 1'b0, AW'(7), '0, 1'b0, AW'(7), '0);
    chk("R9", "u0 word7", q0_a, DW'(7 * 37 + 5));
    chk("R9", "u1 word7", q1_b, DW'(7 * 37 + 5));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) kn[i] = 1'b0;
    t_reset();
    t_fill();
    t_collide();
    t_cross();
    t_single();
    t_ignore();
    idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule